// File: doc/BRIEF.md
# Tile Transpose Engine

This block holds a source tile of 32-bit elements in a local register array and produces its transpose in a separate destination array. The tile is 16 rows by 64 bytes, which is 16 dwords per row. Source rows come in through a write port. A start pulse carries the output geometry: a destination row count, and a destination row width in bytes.

The engine works on one source row per cycle. It reads source row j and scatters its dwords into column j of every valid destination row. After the last column it spends one cycle clearing everything outside the configured window. Rows at or beyond the row count, and dword positions at or beyond width/4, are left at zero. A busy/done handshake marks the run. If the configuration is illegal, the engine raises an error flag and leaves the destination as it was. Destination rows are read back through a combinational read port.

Top module: `tile_transpose_engine`

## Requirements
- R1: After reset `busy`, `done` and `cfg_err` are low and every destination row reads as zero.
- R2: While idle, a high `ld_en` at a clock edge stores `ld_data` into source row `ld_row`. Source dword k occupies bits [32k+31:32k].
- R3: A legal run makes destination row i, dword j equal to source row j, dword i, for every i below `cfg_rows` and every j below `cfg_bytes`/4. Destination dword k occupies bits [32k+31:32k] of `rd_data`.
- R4: After a legal run, every destination dword at position `cfg_bytes`/4 or above reads as zero in every row.
- R5: After a legal run, every destination row at index `cfg_rows` or above reads as zero in full.
- R6: Let N = `cfg_bytes`/4. For a legal start sampled at edge k, `busy` is high from edge k until edge k+N+1. `done` is high for exactly the one cycle after edge k+N+1, and `busy` is low during that cycle.
- R7: A start whose `cfg_bytes` is not a multiple of 4 or is above 64, or whose `cfg_rows` is above 16, is illegal. It sets `cfg_err` and pulses `done` in the cycle after the start edge. `busy` stays low and the destination is unchanged. A legal start clears `cfg_err`.
- R8: A start pulse while `busy` is high is ignored. The run in progress completes with its own geometry and timing.
- R9: A load (`ld_en`) while `busy` is high is ignored. It does not change the result of the run in progress, and it does not change the stored source afterwards.
- R10: A legal start with `cfg_bytes` = 0 runs for one busy cycle, and afterwards the whole destination reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Source row write strobe |
| ld_row | input | 4 | Source row index to write |
| ld_data | input | 512 | Source row data, 16 dwords |
| start | input | 1 | Start pulse, sampled while idle |
| cfg_rows | input | 5 | Destination row count (0..16 legal) |
| cfg_bytes | input | 7 | Destination row width in bytes (multiple of 4, 0..64 legal) |
| busy | output | 1 | High while a legal run is in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last accepted start had an illegal configuration |
| rd_row | input | 4 | Destination row index to read |
| rd_data | output | 512 | Destination row contents (combinational) |

## Verification
For a legal start with N dword columns, busy is due the cycle after the start edge and holds for N+1 cycles. Done follows in the next cycle, and the destination content is final from that same cycle. An illegal start shows done and cfg_err one cycle after its edge, with busy never rising. The bench drives inputs and samples outputs on the falling edge. It counts busy samples one by one from the start edge and expects done exactly at sample N+1. It reads the destination only after done has been seen. A start or a load injected in the middle of a run is judged by the run's length and by the destination contents afterwards.

// File: rtl/tt_pkg.sv
package tt_pkg;

  typedef enum logic [1:0] {
    TT_IDLE  = 2'd0,
    TT_COLS  = 2'd1,
    TT_CLEAR = 2'd2
  } tt_state_e;

  // geometry is legal when width is dword aligned and both fit the tile
  function automatic logic tt_cfg_ok(input int rows, input int nbytes,
                                     input int max_rows, input int max_bytes);
    return ((nbytes % 4) == 0) && (nbytes <= max_bytes) && (rows <= max_rows);
  endfunction

  function automatic int tt_dwords(input int nbytes);
    return nbytes / 4;
  endfunction

  // an element survives the final clear only inside the configured window
  function automatic logic tt_keep(input int row, input int dw,
                                   input int rows, input int ndw);
    return (row < rows) && (dw < ndw);
  endfunction

endpackage

// File: rtl/tt_src_bank.sv
module tt_src_bank #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 512,
  localparam int RI_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RI_W-1:0]  wr_row,
  input  logic [ROW_W-1:0] wr_data,
  input  logic [RI_W-1:0]  rd_row,
  output logic [ROW_W-1:0] rd_data
);

  logic [ROW_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr_en) begin
      mem[wr_row] <= wr_data;
    end
  end

  assign rd_data = mem[rd_row];

endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int DWORDS    = 16,
  parameter int CR_W      = 5,
  parameter int CB_W      = 7,
  localparam int MAX_DIM  = (ROWS < DWORDS) ? ROWS : DWORDS,
  localparam int COL_W    = $clog2(DWORDS),
  localparam int NDW_W    = $clog2(DWORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CR_W-1:0]  cfg_rows,
  input  logic [CB_W-1:0]  cfg_bytes,
  output logic             busy,
  output logic             done,
  output logic             cfg_err,
  output logic             col_we,
  output logic             clr_we,
  output logic [COL_W-1:0] col_idx,
  output logic [CR_W-1:0]  lat_rows,
  output logic [NDW_W-1:0] lat_ndw
);

  tt_state_e  state;
  logic       cfg_ok;
  logic [NDW_W-1:0] req_ndw;
  logic       last_col;

  assign cfg_ok   = tt_cfg_ok(int'(cfg_rows), int'(cfg_bytes), MAX_DIM, MAX_DIM * 4);
  assign req_ndw  = NDW_W'(tt_dwords(int'(cfg_bytes)));
  assign last_col = (NDW_W'(col_idx) + NDW_W'(1)) == lat_ndw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= TT_IDLE;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
      col_idx  <= '0;
      lat_rows <= '0;
      lat_ndw  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        TT_IDLE: begin
          if (start) begin
            if (cfg_ok) begin
              cfg_err  <= 1'b0;
              lat_rows <= cfg_rows;
              lat_ndw  <= req_ndw;
              col_idx  <= '0;
              state    <= (req_ndw == '0) ? TT_CLEAR : TT_COLS;
            end else begin
              cfg_err <= 1'b1;
              done    <= 1'b1;
            end
          end
        end
        TT_COLS: begin
          if (last_col) state <= TT_CLEAR;
          else          col_idx <= col_idx + COL_W'(1);
        end
        TT_CLEAR: begin
          state <= TT_IDLE;
          done  <= 1'b1;
        end
        default: state <= TT_IDLE;
      endcase
    end
  end

  assign busy   = (state != TT_IDLE);
  assign col_we = (state == TT_COLS);
  assign clr_we = (state == TT_CLEAR);

endmodule

// File: rtl/tt_dst_bank.sv
module tt_dst_bank
  import tt_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int DWORDS = 16,
  parameter int EW     = 32,
  parameter int CR_W   = 5,
  localparam int ROW_W = DWORDS * EW,
  localparam int RI_W  = $clog2(ROWS),
  localparam int COL_W = $clog2(DWORDS),
  localparam int NDW_W = $clog2(DWORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_we,
  input  logic [COL_W-1:0] col_idx,
  input  logic [ROW_W-1:0] src_row,
  input  logic [CR_W-1:0]  lat_rows,
  input  logic [NDW_W-1:0] lat_ndw,
  input  logic             clr_we,
  input  logic [RI_W-1:0]  rd_row,
  output logic [ROW_W-1:0] rd_data
);

  logic [EW-1:0] mem [ROWS][DWORDS];

  // column write: source dword r lands in destination row r, column col_idx
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int d = 0; d < DWORDS; d++) mem[r][d] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        for (int d = 0; d < DWORDS; d++) begin
          if (clr_we && !tt_keep(r, d, int'(lat_rows), int'(lat_ndw)))
            mem[r][d] <= '0;
          else if (col_we && (d == int'(col_idx)) && (r < int'(lat_rows)) && (r < DWORDS))
            mem[r][d] <= src_row[r*EW +: EW];
        end
      end
    end
  end

  always_comb begin
    for (int d = 0; d < DWORDS; d++) rd_data[d*EW +: EW] = mem[rd_row][d];
  end

endmodule

// File: rtl/tile_transpose_engine.sv
module tile_transpose_engine #(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  parameter int EW        = 32,
  localparam int DWORDS   = ROW_BYTES / (EW / 8),
  localparam int ROW_W    = DWORDS * EW,
  localparam int RI_W     = $clog2(ROWS),
  localparam int CR_W     = $clog2(ROWS + 1),
  localparam int CB_W     = $clog2(ROW_BYTES + 1),
  localparam int COL_W    = $clog2(DWORDS),
  localparam int NDW_W    = $clog2(DWORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [RI_W-1:0]  ld_row,
  input  logic [ROW_W-1:0] ld_data,
  input  logic             start,
  input  logic [CR_W-1:0]  cfg_rows,
  input  logic [CB_W-1:0]  cfg_bytes,
  output logic             busy,
  output logic             done,
  output logic             cfg_err,
  input  logic [RI_W-1:0]  rd_row,
  output logic [ROW_W-1:0] rd_data
);

  // internal events, named for the checker
  logic             col_we;
  logic             clr_we;
  logic [COL_W-1:0] col_idx;
  logic [CR_W-1:0]  lat_rows;
  logic [NDW_W-1:0] lat_ndw;
  logic             src_we;
  logic [ROW_W-1:0] src_row;

  assign src_we = ld_en && !busy;

  tt_src_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (src_we),
    .wr_row  (ld_row),
    .wr_data (ld_data),
    .rd_row  (RI_W'(col_idx)),
    .rd_data (src_row)
  );

  tt_ctrl #(.ROWS(ROWS), .DWORDS(DWORDS), .CR_W(CR_W), .CB_W(CB_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_rows  (cfg_rows),
    .cfg_bytes (cfg_bytes),
    .busy      (busy),
    .done      (done),
    .cfg_err   (cfg_err),
    .col_we    (col_we),
    .clr_we    (clr_we),
    .col_idx   (col_idx),
    .lat_rows  (lat_rows),
    .lat_ndw   (lat_ndw)
  );

  tt_dst_bank #(.ROWS(ROWS), .DWORDS(DWORDS), .EW(EW), .CR_W(CR_W)) u_dst (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_we   (col_we),
    .col_idx  (col_idx),
    .src_row  (src_row),
    .lat_rows (lat_rows),
    .lat_ndw  (lat_ndw),
    .clr_we   (clr_we),
    .rd_row   (rd_row),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int COL_W = 4,
  parameter int NDW_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             cfg_err,
  input logic             col_we,
  input logic             clr_we,
  input logic [COL_W-1:0] col_idx,
  input logic [NDW_W-1:0] lat_ndw
);

  // R6: completion never overlaps the busy window
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: the clear cycle is followed by done with busy dropped
  a_r6_clear_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (done && !busy));

  // R6: the column walk stays inside the latched width
  a_r6_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    col_we |-> (NDW_W'(col_idx) < lat_ndw));

  // R3: columns are visited in order, one per cycle
  a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_we && ((NDW_W'(col_idx) + NDW_W'(1)) != lat_ndw))
      |=> (col_we && (col_idx == $past(col_idx) + COL_W'(1))));

  // R7: an error completion comes from an idle start
  a_r7_err_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_err) |-> ($past(start) && !$past(busy)));

  // R8: nothing ends a run before its clear cycle
  a_r8_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr_we) |=> busy);

endmodule

bind tile_transpose_engine tt_checker #(.COL_W(COL_W), .NDW_W(NDW_W)) u_tt_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .cfg_err (cfg_err),
  .col_we  (col_we),
  .clr_we  (clr_we),
  .col_idx (col_idx),
  .lat_ndw (lat_ndw)
);

// File: tb/test_tile_transpose_engine.sv
module test_tile_transpose_engine;

  localparam int ROWS = 16;
  localparam int DWS  = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_en = 1'b0;
  logic [3:0]   ld_row = '0;
  logic [511:0] ld_data = '0;
  logic         start = 1'b0;
  logic [4:0]   cfg_rows = '0;
  logic [6:0]   cfg_bytes = '0;
  logic         busy, done, cfg_err;
  logic [3:0]   rd_row = '0;
  logic [511:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [511:0] m_src [ROWS];
  logic [511:0] m_exp [ROWS];

  always #10 clk = ~clk;

  tile_transpose_engine i_tile_transpose_engine (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_data(ld_data),
    .start(start), .cfg_rows(cfg_rows), .cfg_bytes(cfg_bytes),
    .busy(busy), .done(done), .cfg_err(cfg_err),
    .rd_row(rd_row), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected destination, built from the element rule of R3/R4/R5
  task automatic build_exp(input int rows, input int nbytes);
    for (int i = 0; i < ROWS; i++) begin
      m_exp[i] = '0;
      if (i < rows)
        for (int j = 0; j < nbytes / 4; j++) m_exp[i][32*j +: 32] = m_src[j][32*i +: 32];
    end
  endtask

  task automatic check_dst(input string req);
    for (int r = 0; r < ROWS; r++) begin
      rd_row = 4'(r);
      #1;
      chk(rd_data === m_exp[r], req, rd_data, m_exp[r]);
    end
  endtask

  // R2: fill the source while idle
  task automatic load_src(input int seed);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      ld_en  = 1'b1;
      ld_row = 4'(r);
      for (int d = 0; d < DWS; d++)
        ld_data[32*d +: 32] = {8'(seed), 8'(r), 8'(d), 8'h5A ^ 8'(seed + r)};
      m_src[r] = ld_data;
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // mode 0: plain, 1: start while busy (R8), 2: load while busy (R9)
  task automatic run_legal(input int rows, input int nbytes, input int mode, input string req);
    int n = nbytes / 4;
    @(negedge clk);
    start = 1'b1; cfg_rows = 5'(rows); cfg_bytes = 7'(nbytes);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= n; c++) begin
      chk(busy === 1'b1 && done === 1'b0, {req, " R6 busy window"}, {busy, done}, 2'b10);
      start = 1'b0; ld_en = 1'b0;
      if (c == 2 && mode == 1) begin
        start = 1'b1; cfg_rows = 5'd3; cfg_bytes = 7'd12;
      end
      if (c == 2 && mode == 2) begin
        ld_en = 1'b1; ld_row = 4'd15; ld_data = {16{32'hDEAD_BEEF}};
      end
      @(negedge clk);
    end
    start = 1'b0; ld_en = 1'b0;
    chk(done === 1'b1 && busy === 1'b0 && cfg_err === 1'b0, {req, " R6 done"},
        {busy, done, cfg_err}, 3'b010);
    build_exp(rows, nbytes);
    check_dst(req);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {req, " R6 single done"}, {busy, done}, 2'b00);
  endtask

  task automatic run_illegal(input int rows, input int nbytes, input string req);
    @(negedge clk);
    start = 1'b1; cfg_rows = 5'(rows); cfg_bytes = 7'(nbytes);
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0 && cfg_err === 1'b1, req,
        {busy, done, cfg_err}, 3'b011);
    check_dst({req, " dst unchanged"});
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && cfg_err === 1'b1, {req, " after"},
        {busy, done, cfg_err}, 3'b001);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && done === 1'b0 && cfg_err === 1'b0, "R1 flags",
        {busy, done, cfg_err}, 3'b000);
    for (int r = 0; r < ROWS; r++) m_exp[r] = '0;
    check_dst("R1 dst zero");

    load_src(1);
    run_legal(16, 64, 0, "R3 R2 full tile");
    run_legal(5, 24, 0, "R4 R5 partial 5x24");
    run_legal(16, 8, 0, "R4 narrow width");
    run_legal(0, 64, 0, "R5 zero rows");
    load_src(7);
    run_legal(11, 44, 0, "R3 new source 11x44");
    run_legal(9, 0, 0, "R10 zero width");

    load_src(3);
    run_legal(16, 64, 0, "R3 baseline");
    run_illegal(16, 10, "R7 width not dword aligned");
    run_illegal(16, 68, "R7 width too large");
    run_illegal(17, 64, "R7 too many rows");
    run_legal(7, 28, 0, "R7 legal clears error");

    run_legal(16, 64, 1, "R8 start while busy");
    run_legal(14, 64, 2, "R9 load while busy");
    run_legal(16, 64, 0, "R9 source kept after busy load");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule